// File: doc/BRIEF.md
# Multi-Mode Symbol-to-Chip Spreader

The spreader takes data symbols over a valid/ready handshake and sends each one as a serial run of binary chips. The chips feed a BPSK or OQPSK modulator at the chip rate. It supports three short code sets, selected per symbol:

- a 16-chip set that carries 4 bits per symbol;
- an 8-chip set that carries 4 bits per symbol;
- an 8-chip set that carries 3 bits per symbol.

No chip table is stored. Each code set is defined by a single root word. The sequence for a symbol is that root rotated cyclically by an amount taken from the symbol's low bits. When the symbol's top bit is set, the chips at odd positions are then inverted.

A chip-rate strobe paces the output. Each strobe that arrives while a symbol is in progress produces one chip, marked valid for one cycle. The final chip of the symbol also carries a last flag. When no symbol is in progress the output stays quiet, so no filler chips are produced.

The control is a two-state machine:

- `IDLE`: ready is high, and nothing is emitted.
- `SEND`: the latched pattern is shifted out, one chip per strobe.

There are two transitions:

- `ACCEPT` (`IDLE` to `SEND`): a handshake occurs. The generated pattern, its last-chip index and a zeroed chip index are latched.
- `DONE` (`SEND` to `IDLE`): a strobe emits the chip whose index equals the latched last index.

Top module: `chip_spreader`

## Requirements
- R1: While reset is low, and in the first cycle after it, sym_ready is 1 and chip_valid, chip_out and chip_last are 0.
- R2: A symbol is taken on a rising edge where sym_valid and sym_ready are both 1. sym_ready is then 0 until the cycle in which the last chip of that symbol is shown, when it returns to 1.
- R3: Each chip_en=1 edge during a symbol gives chip_valid=1 for exactly the next cycle. A chip_en=0 edge gives chip_valid=0 in the next cycle.
- R4: Chips leave in index order 0, 1, 2, … Chip i of a root word is bit i of that word, where bit 0 is the LSB.
- R5: mode_sel selects the code set as follows.
  - 0: 16 chips, root 0x3AFC, 4 bits per symbol.
  - 1: 8 chips, root 0xB2, 4 bits per symbol.
  - 2: 8 chips, root 0x45, 3 bits per symbol; sym_data[3] is ignored.
  - 3: behaves as 0.
- R6: In mode 0, chip i of symbol s equals root[(i − 2·(s mod 8)) mod 16], XORed with 1 when s[3]=1 and i is odd.
- R7: In mode 1, chip i of symbol s equals root[(i − (s mod 8)) mod 8], XORed with 1 when s[3]=1 and i is odd.
- R8: In mode 2, chip i of symbol s equals root[(i − 2·(s mod 4)) mod 8], XORed with 1 when s[2]=1 and i is odd.
- R9: chip_last is 1 together with the final chip (index 15 or 7) and is 0 with every other chip.
- R10: Changes on mode_sel, sym_data or sym_valid while a symbol is being sent do not alter that symbol's chips.
- R11: When no symbol is in progress, chip_en strobes produce chip_valid=0 and chip_out=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_valid | input | 1 | Symbol offered |
| sym_ready | output | 1 | Spreader can take a symbol |
| sym_data | input | 4 | Symbol value |
| mode_sel | input | 2 | Code set select, sampled with the symbol |
| chip_en | input | 1 | Chip-rate strobe |
| chip_out | output | 1 | Current chip |
| chip_valid | output | 1 | chip_out holds a new chip this cycle |
| chip_last | output | 1 | Current chip is the symbol's final chip |

## Verification
The hardest situation to reach from the ports is a change on the mode and data inputs in the middle of a symbol, with strobes arriving irregularly. The same applies when the final strobe of one symbol and a fresh offer sit back to back.

The bench drives random strobe densities and, for most symbols, randomises mode_sel, sym_data and sym_valid on every cycle of the symbol. Each chip is compared with a sequence computed by index arithmetic from the requirements. Directed cases cover every root, the highest symbols, mode 3, the ignored top bit in the 3-bit set, and long idle strobing.

// File: rtl/spreader_pkg.sv
package spreader_pkg;
    localparam int CHIPS_LONG  = 16;
    localparam int CHIPS_SHORT = 8;
    localparam int SYM_W       = 4;
    localparam int IDX_W       = $clog2(CHIPS_LONG);

    typedef enum logic [1:0] {
        MODE_L16   = 2'd0,
        MODE_S8Q   = 2'd1,
        MODE_S8T   = 2'd2,
        MODE_ALT16 = 2'd3
    } code_mode_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } spread_state_t;
endpackage

// File: rtl/spreader_seqgen.sv
module spreader_seqgen
    import spreader_pkg::*;
#(
    parameter logic [CHIPS_LONG-1:0]  ROOT_L16 = 16'h3AFC,
    parameter logic [CHIPS_SHORT-1:0] ROOT_S8Q = 8'hB2,
    parameter logic [CHIPS_SHORT-1:0] ROOT_S8T = 8'h45
) (
    input  logic [1:0]            mode,
    input  logic [SYM_W-1:0]      sym,
    output logic [CHIPS_LONG-1:0] pattern,
    output logic [IDX_W-1:0]      last_idx
);
    // Mask of odd chip positions, built per chip index.
    logic [CHIPS_LONG-1:0] odd_mask;
    genvar g;
    generate
        for (g = 0; g < CHIPS_LONG; g++) begin : g_odd
            assign odd_mask[g] = (g % 2) == 1;
        end
    endgenerate

    int unsigned shift;
    logic        invert;
    logic        is_long;
    logic [CHIPS_LONG-1:0]  rot_long;
    logic [CHIPS_SHORT-1:0] rot_short;
    logic [CHIPS_SHORT-1:0] root_short;

    always_comb begin
        unique case (code_mode_t'(mode))
            MODE_S8Q: begin
                is_long    = 1'b0;
                root_short = ROOT_S8Q;
                shift      = int'(sym[2:0]);
                invert     = sym[3];
            end
            MODE_S8T: begin
                is_long    = 1'b0;
                root_short = ROOT_S8T;
                shift      = 2 * int'(sym[1:0]);
                invert     = sym[2];
            end
            default: begin
                is_long    = 1'b1;
                root_short = ROOT_S8Q;
                shift      = 2 * int'(sym[2:0]);
                invert     = sym[3];
            end
        endcase
    end

    // Cyclic rotation towards higher chip index.
    always_comb begin
        for (int i = 0; i < CHIPS_LONG; i++)
            rot_long[i] = ROOT_L16[(i + CHIPS_LONG - (shift % CHIPS_LONG)) % CHIPS_LONG];
        for (int i = 0; i < CHIPS_SHORT; i++)
            rot_short[i] = root_short[(i + CHIPS_SHORT - (shift % CHIPS_SHORT)) % CHIPS_SHORT];
    end

    always_comb begin
        if (is_long) begin
            pattern  = rot_long ^ (invert ? odd_mask : '0);
            last_idx = IDX_W'(CHIPS_LONG - 1);
        end else begin
            pattern  = {{(CHIPS_LONG-CHIPS_SHORT){1'b0}},
                        rot_short ^ (invert ? odd_mask[CHIPS_SHORT-1:0] : '0)};
            last_idx = IDX_W'(CHIPS_SHORT - 1);
        end
    end
endmodule

// File: rtl/spreader_ctrl.sv
module spreader_ctrl
    import spreader_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sym_valid,
    output logic                  sym_ready,
    input  logic                  chip_en,
    input  logic [CHIPS_LONG-1:0] pat_in,
    input  logic [IDX_W-1:0]      last_in,
    output logic                  chip_out,
    output logic                  chip_valid,
    output logic                  chip_last
);
    spread_state_t         state_q, state_d;
    logic [CHIPS_LONG-1:0] pat_q;
    logic [IDX_W-1:0]      last_q;
    logic [IDX_W-1:0]      idx_q;
    logic                  take_sym;
    logic                  emit;
    logic                  at_end;

    assign sym_ready = (state_q == ST_IDLE);
    assign take_sym  = sym_ready && sym_valid;
    assign emit      = (state_q == ST_SEND) && chip_en;
    assign at_end    = (idx_q == last_q);

    // Next-state logic: ACCEPT and DONE transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (take_sym)        state_d = ST_SEND;
            ST_SEND: if (emit && at_end)  state_d = ST_IDLE;
            default:                      state_d = ST_IDLE;
        endcase
    end

    // State register with latched symbol context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pat_q   <= '0;
            last_q  <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (take_sym) begin
                pat_q  <= pat_in;
                last_q <= last_in;
                idx_q  <= '0;
            end else if (emit) begin
                idx_q  <= idx_q + 1'b1;
            end
        end
    end

    // Output register: one chip per strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chip_out   <= 1'b0;
            chip_valid <= 1'b0;
            chip_last  <= 1'b0;
        end else if (emit) begin
            chip_out   <= pat_q[idx_q];
            chip_valid <= 1'b1;
            chip_last  <= at_end;
        end else begin
            chip_out   <= 1'b0;
            chip_valid <= 1'b0;
            chip_last  <= 1'b0;
        end
    end

    // R3: a chip appears only after a strobe
    a_r3_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        chip_valid |-> $past(chip_en));
    // R9: last flag only on a valid chip
    a_r9_last_is_valid: assert property (@(posedge clk) disable iff (!rst_n)
        chip_last |-> chip_valid);
    // R2: ready comes back with the last chip
    a_r2_ready_with_last: assert property (@(posedge clk) disable iff (!rst_n)
        chip_last |-> sym_ready);
    // R2: ready drops after a handshake
    a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && sym_ready) |=> !sym_ready);
    // R11: no chip follows an idle cycle
    a_r11_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sym_ready) |-> !chip_valid);
    // R9: the chip index never passes the last index while sending
    a_r9_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEND) |-> (idx_q <= last_q));
endmodule

// File: rtl/chip_spreader.sv
module chip_spreader
    import spreader_pkg::*;
#(
    parameter logic [CHIPS_LONG-1:0]  ROOT_L16 = 16'h3AFC,
    parameter logic [CHIPS_SHORT-1:0] ROOT_S8Q = 8'hB2,
    parameter logic [CHIPS_SHORT-1:0] ROOT_S8T = 8'h45
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sym_valid,
    output logic             sym_ready,
    input  logic [SYM_W-1:0] sym_data,
    input  logic [1:0]       mode_sel,
    input  logic             chip_en,
    output logic             chip_out,
    output logic             chip_valid,
    output logic             chip_last
);
    logic [CHIPS_LONG-1:0] gen_pattern;
    logic [IDX_W-1:0]      gen_last;

    spreader_seqgen #(
        .ROOT_L16 (ROOT_L16),
        .ROOT_S8Q (ROOT_S8Q),
        .ROOT_S8T (ROOT_S8T)
    ) i_seqgen (
        .mode     (mode_sel),
        .sym      (sym_data),
        .pattern  (gen_pattern),
        .last_idx (gen_last)
    );

    spreader_ctrl i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sym_valid  (sym_valid),
        .sym_ready  (sym_ready),
        .chip_en    (chip_en),
        .pat_in     (gen_pattern),
        .last_in    (gen_last),
        .chip_out   (chip_out),
        .chip_valid (chip_valid),
        .chip_last  (chip_last)
    );
endmodule

// File: tb/test_chip_spreader.sv
module test_chip_spreader;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sym_valid = 1'b0;
    logic       sym_ready;
    logic [3:0] sym_data = '0;
    logic [1:0] mode_sel = '0;
    logic       chip_en = 1'b0;
    logic       chip_out, chip_valid, chip_last;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chip_spreader i_chip_spreader (
        .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_ready(sym_ready),
        .sym_data(sym_data), .mode_sel(mode_sel), .chip_en(chip_en),
        .chip_out(chip_out), .chip_valid(chip_valid), .chip_last(chip_last)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int seq_len(input int mode);
        return (mode == 1 || mode == 2) ? 8 : 16;
    endfunction

    // Expected chip from the index formulas of R5..R8.
    function automatic bit exp_chip(input int mode, input int sym, input int i);
        int n, sh, inv;
        logic [15:0] root;
        case (mode)
            1:       begin n = 8;  root = 16'h00B2; sh = sym % 8;       inv = (sym / 8) % 2; end
            2:       begin n = 8;  root = 16'h0045; sh = 2 * (sym % 4); inv = (sym / 4) % 2; end
            default: begin n = 16; root = 16'h3AFC; sh = 2 * (sym % 8); inv = (sym / 8) % 2; end
        endcase
        return root[(i - sh + n) % n] ^ ((inv == 1) && (i % 2 == 1));
    endfunction

    function automatic string mode_tag(input int mode);
        case (mode)
            1:       return "R7";
            2:       return "R8";
            default: return "R6";
        endcase
    endfunction

    // Sends one symbol; chips are compared in index order (R4).
    task automatic run_symbol(input int mode, input int sym, input int en_pct, input bit noisy);
        int n = seq_len(mode);
        int k = 0;
        string tag = noisy ? {mode_tag(mode), "/R10"} : mode_tag(mode);
        check(sym_ready === 1'b1, "R2 ready before offer", int'(sym_ready), 1);
        sym_valid = 1'b1;
        sym_data  = 4'(sym);
        mode_sel  = 2'(mode);
        chip_en   = 1'b0;
        @(negedge clk);
        sym_valid = 1'b0;
        check(sym_ready === 1'b0, "R2 ready after accept", int'(sym_ready), 0);
        while (k < n) begin
            chip_en = ($urandom % 100) < en_pct;
            if (noisy) begin
                mode_sel  = 2'($urandom);
                sym_data  = 4'($urandom);
                sym_valid = 1'($urandom);
            end
            @(negedge clk);
            if (chip_en) begin
                bit e = exp_chip(mode, sym, k);
                check(chip_valid === 1'b1 && chip_out === e, {tag, " R4 chip"},
                      int'({chip_valid, chip_out}), int'({1'b1, e}));
                check(chip_last === (k == n - 1), "R9 last flag", int'(chip_last), int'(k == n - 1));
                check(sym_ready === (k == n - 1), "R2 ready during symbol", int'(sym_ready), int'(k == n - 1));
                k++;
            end else begin
                check(chip_valid === 1'b0, "R3 no strobe no chip", int'(chip_valid), 0);
            end
        end
        sym_valid = 1'b0;
        chip_en   = 1'b0;
    endtask

    task automatic idle_strobes(input int cycles);
        for (int c = 0; c < cycles; c++) begin
            chip_en = 1'b1;
            sym_data = 4'($urandom);
            mode_sel = 2'($urandom);
            @(negedge clk);
            check(chip_valid === 1'b0 && chip_out === 1'b0 && chip_last === 1'b0,
                  "R11 idle output", int'({chip_valid, chip_out, chip_last}), 0);
        end
        chip_en = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(sym_ready === 1'b1 && chip_valid === 1'b0 && chip_out === 1'b0 && chip_last === 1'b0,
              "R1 reset state", int'({sym_ready, chip_valid, chip_out, chip_last}), 8);
        rst_n = 1'b1;
        @(negedge clk);
        check(sym_ready === 1'b1 && chip_valid === 1'b0, "R1 after reset",
              int'({sym_ready, chip_valid}), 2);
        // Directed corners: every root, top symbols, mode 3, ignored bit (R5).
        run_symbol(0, 0, 100, 0);
        run_symbol(0, 15, 100, 0);
        run_symbol(1, 0, 100, 0);
        run_symbol(1, 15, 60, 0);
        run_symbol(2, 0, 100, 0);
        run_symbol(2, 7, 100, 0);
        run_symbol(2, 12, 100, 0);  // R5: bit 3 ignored, same as symbol 4
        run_symbol(3, 9, 100, 0);   // R5: mode 3 acts as mode 0
        idle_strobes(5);
        // Every symbol of every mode.
        for (int m = 0; m < 3; m++)
            for (int s = 0; s < 16; s++)
                run_symbol(m, s, 100, 0);
        // Constrained random.
        for (int r = 0; r < 300; r++) begin
            run_symbol(int'($urandom % 4), int'($urandom % 16), 20 + int'($urandom % 81), (r % 4) != 0);
            if ($urandom % 8 == 0) idle_strobes(1 + int'($urandom % 4));
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule